// File: doc/BRIEF.md
# Partition-Selected Ternary Match Array

This block is a small ternary lookup array whose entries are split into disjoint groups. Every group carries its own ternary selector code. A search runs in two steps. The key is first resolved against the group selector codes, and exactly one group is chosen. Only the entries of that group are then compared against the key. The compare logic of every other group is held inactive. This mirrors the power saving of searching only a fraction of a large array.

The registered result holds three things: the hit vector of the chosen group, the group number and a flag for the case where no selector code matched. The hit vector goes to a downstream encoder that reports several matches. By construction, the highest-numbered group only holds entries that overlap no other entry, so a search that lands there yields at most one hit. For that group the block also reports the hit index through a plain lowest-index encoder. One write port loads entry words, their care masks and group membership, and also loads the selector codes. The grouping itself is computed offline.

Top module: `partsel_tcam`

## Requirements
- R1: An entry matches when it has been written and every bit whose care bit is 1 equals the corresponding key bit. Bits whose care bit is 0 are don't-care.
- R2: A selector code matches under the same ternary rule, and a code that has never been written matches nothing. When several codes match, the lowest-numbered group is selected and reported on `res_part`.
- R3: When no selector code matches, the search returns `res_nomatch` = 1, an all-zero hit vector, `res_part` = 0 and `res_one_hit` = 0.
- R4: Bit i of `res_hits` can be 1 only if entry i belongs to the selected group. Entries of all other groups read as 0, even when they would match the key.
- R5: A search presented with `srch_valid` at clock edge t produces `res_valid` = 1 and updated results after edge t, for exactly one cycle per search. Without a search, the result outputs hold their values.
- R6: A write takes effect for a search presented in the cycle after the write. Writes and searches are never presented in the same cycle.
- R7: After reset, all outputs are 0 and no entry or code is valid, so a search returns `res_nomatch` = 1.
- R8: When the selected group is the last one (number NUM_PART-1) and its hit vector is non-zero, `res_one_hit` = 1 and `res_one_idx` is the lowest set index. Otherwise both are 0.
- R9: With entries 1101xx10, 11x1xxxx, 100x1xx0, 1001x110 and 1x01xx10 in group 1 (code 1x01xxxx), the key 11010010 selects group 1 and hits the first, second and fifth of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 1 | 0: entry write, 1: selector code write |
| wr_addr | input | IDX_W | Entry index, or group number in its low PART_W bits |
| wr_value | input | KEY_W | Ternary value bits |
| wr_care | input | KEY_W | Care mask, 1 = bit is compared |
| wr_part | input | PART_W | Group membership of the written entry |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | KEY_W | Search key |
| res_valid | output | 1 | Result valid, one cycle per search |
| res_hits | output | NUM_ENT | Hit vector of the selected group |
| res_part | output | PART_W | Selected group number |
| res_nomatch | output | 1 | No selector code matched |
| res_one_hit | output | 1 | Last group selected and hit |
| res_one_idx | output | IDX_W | Lowest hit index in the last group |

## Verification
The bench builds the block with 8-bit keys, 16 entries and 4 groups. With these values the 8-bit example entries and key can be loaded word for word. They also leave unwritten entries in place to show that invalid slots never hit, and they let an all-don't-care entry sit in a non-selected group to show gating. With only four groups, overlapping selector codes and the no-code-match case are cheap to build, and a few hundred random keys cover every group several times.

// File: rtl/partsel_tcam_pkg.sv
// Shared definitions for the partition-selected ternary match array.
// Assumes: nothing beyond IEEE 1800-2017.
package partsel_tcam_pkg;

    // Destination of a write on the shared write port
    typedef enum logic {
        WR_ENTRY = 1'b0,
        WR_CODE  = 1'b1
    } wr_target_e;

endpackage

// File: rtl/ptcam_resolver.sv
// Group resolver: stores one ternary selector code per group and picks the
// lowest-numbered group whose code matches the key.
// Assumes: writes and searches never share a cycle; unwritten codes never match.
module ptcam_resolver #(
    parameter int KEY_W    = 8,
    parameter int NUM_PART = 4,
    localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PART_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_care,
    input  logic [KEY_W-1:0]  key,
    input  logic              enable,
    output logic              sel_en,
    output logic [PART_W-1:0] sel_part
);

    logic [NUM_PART-1:0] code_hit;

    for (genvar p = 0; p < NUM_PART; p++) begin : g_code
        logic [KEY_W-1:0] val_q;
        logic [KEY_W-1:0] care_q;
        logic             vld_q;

        // Load or clear this group's selector code
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= '0;
                care_q <= '0;
                vld_q  <= 1'b0;
            end else if (wr_en && wr_addr == PART_W'(p)) begin
                val_q  <= wr_value;
                care_q <= wr_care;
                vld_q  <= 1'b1;
            end
        end

        assign code_hit[p] = vld_q && (((key ^ val_q) & care_q) == '0);
    end

    // Lowest-numbered matching group wins
    always_comb begin
        sel_part = '0;
        for (int p = NUM_PART - 1; p >= 0; p--) begin
            if (code_hit[p]) sel_part = PART_W'(p);
        end
        sel_en = enable && (|code_hit);
    end

endmodule

// File: rtl/ptcam_entry_bank.sv
// Entry bank: stores ternary entries with group membership and evaluates only
// the entries of the group picked by the resolver; all others read as zero.
// Assumes: writes and searches never share a cycle; unwritten entries never hit.
module ptcam_entry_bank #(
    parameter int KEY_W    = 8,
    parameter int NUM_ENT  = 16,
    parameter int NUM_PART = 4,
    localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic [PART_W-1:0]  wr_part,
    input  logic [KEY_W-1:0]   key,
    input  logic               sel_en,
    input  logic [PART_W-1:0]  sel_part,
    output logic [NUM_ENT-1:0] hits
);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic [KEY_W-1:0]  val_q;
        logic [KEY_W-1:0]  care_q;
        logic [PART_W-1:0] part_q;
        logic              vld_q;
        logic              in_group;

        // Load or clear this entry's word, mask and group
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= '0;
                care_q <= '0;
                part_q <= '0;
                vld_q  <= 1'b0;
            end else if (wr_en && wr_addr == IDX_W'(e)) begin
                val_q  <= wr_value;
                care_q <= wr_care;
                part_q <= wr_part;
                vld_q  <= 1'b1;
            end
        end

        // Compare is gated off unless this entry's group is the selected one
        assign in_group = sel_en && vld_q && (part_q == sel_part);
        assign hits[e]  = in_group && (((key ^ val_q) & care_q) == '0);
    end

endmodule

// File: rtl/ptcam_onehit_enc.sv
// Plain lowest-index encoder for the catch-all group, which holds at most one
// hit by construction.
// Assumes: hits already carries only the selected group's bits.
module ptcam_onehit_enc #(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] hits,
    input  logic               active,
    output logic               one_hit,
    output logic [IDX_W-1:0]   one_idx
);

    // Pick the lowest set index when the catch-all group is active
    always_comb begin
        one_idx = '0;
        if (active) begin
            for (int e = NUM_ENT - 1; e >= 0; e--) begin
                if (hits[e]) one_idx = IDX_W'(e);
            end
        end
        one_hit = active && (|hits);
    end

endmodule

// File: rtl/partsel_tcam.sv
// Partition-selected ternary match array top. A search key is resolved against
// group selector codes, one group's entries are compared, and the result is
// registered one cycle after the key.
// Assumes: NUM_ENT >= NUM_PART; writes and searches never share a cycle.
module partsel_tcam
    import partsel_tcam_pkg::*;
#(
    parameter int KEY_W    = 8,
    parameter int NUM_ENT  = 16,
    parameter int NUM_PART = 4,
    localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_target,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic [PART_W-1:0]  wr_part,
    input  logic               srch_valid,
    input  logic [KEY_W-1:0]   srch_key,
    output logic               res_valid,
    output logic [NUM_ENT-1:0] res_hits,
    output logic [PART_W-1:0]  res_part,
    output logic               res_nomatch,
    output logic               res_one_hit,
    output logic [IDX_W-1:0]   res_one_idx
);

    localparam logic [PART_W-1:0] LAST_PART = PART_W'(NUM_PART - 1);

    logic               wr_entry;
    logic               wr_code;
    logic               sel_en;
    logic [PART_W-1:0]  sel_part;
    logic [NUM_ENT-1:0] hits;
    logic               catch_all;
    logic               one_hit;
    logic [IDX_W-1:0]   one_idx;

    assign wr_entry  = wr_en && (wr_target_e'(wr_target) == WR_ENTRY);
    assign wr_code   = wr_en && (wr_target_e'(wr_target) == WR_CODE);
    assign catch_all = sel_en && (sel_part == LAST_PART);

    ptcam_resolver #(
        .KEY_W    (KEY_W),
        .NUM_PART (NUM_PART)
    ) u_resolver (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_code),
        .wr_addr  (wr_addr[PART_W-1:0]),
        .wr_value (wr_value),
        .wr_care  (wr_care),
        .key      (srch_key),
        .enable   (srch_valid),
        .sel_en   (sel_en),
        .sel_part (sel_part)
    );

    ptcam_entry_bank #(
        .KEY_W    (KEY_W),
        .NUM_ENT  (NUM_ENT),
        .NUM_PART (NUM_PART)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_entry),
        .wr_addr  (wr_addr),
        .wr_value (wr_value),
        .wr_care  (wr_care),
        .wr_part  (wr_part),
        .key      (srch_key),
        .sel_en   (sel_en),
        .sel_part (sel_part),
        .hits     (hits)
    );

    ptcam_onehit_enc #(
        .NUM_ENT (NUM_ENT)
    ) u_onehit (
        .hits    (hits),
        .active  (catch_all),
        .one_hit (one_hit),
        .one_idx (one_idx)
    );

    // Result strobe: one pulse per search
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= srch_valid;
    end

    // Capture the search result; hold it between searches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hits    <= '0;
            res_part    <= '0;
            res_nomatch <= 1'b0;
            res_one_hit <= 1'b0;
            res_one_idx <= '0;
        end else if (srch_valid) begin
            res_hits    <= hits;
            res_part    <= sel_en ? sel_part : '0;
            res_nomatch <= !sel_en;
            res_one_hit <= one_hit;
            res_one_idx <= one_idx;
        end
    end

endmodule

// File: rtl/partsel_tcam_chk.sv
// Property checker for partsel_tcam, attached by bind.
// Assumes: the same parameter values as the bound instance.
module partsel_tcam_chk #(
    parameter int KEY_W    = 8,
    parameter int NUM_ENT  = 16,
    parameter int NUM_PART = 4,
    localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int PART_W  = (NUM_PART > 1) ? $clog2(NUM_PART) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               srch_valid,
    input logic               res_valid,
    input logic [NUM_ENT-1:0] res_hits,
    input logic [PART_W-1:0]  res_part,
    input logic               res_nomatch,
    input logic               res_one_hit,
    input logic [IDX_W-1:0]   res_one_idx
);

    localparam logic [PART_W-1:0] LAST_PART = PART_W'(NUM_PART - 1);

    // R5
    srch_gives_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> res_valid);

    // R5
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> !res_valid);

    // R5
    hits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> $stable(res_hits) && $stable(res_part));

    // R3
    nomatch_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_nomatch |-> (res_hits == '0) && (res_part == '0) && !res_one_hit);

    // R8
    onehit_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_one_hit |-> (res_part == LAST_PART) && !res_nomatch && res_hits[res_one_idx]);

    // R8
    last_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_nomatch && res_part == LAST_PART && !res_one_hit) |-> (res_hits == '0));

    // R6
    no_wr_in_srch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && srch_valid));

endmodule

bind partsel_tcam partsel_tcam_chk #(
    .KEY_W    (KEY_W),
    .NUM_ENT  (NUM_ENT),
    .NUM_PART (NUM_PART)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .srch_valid  (srch_valid),
    .res_valid   (res_valid),
    .res_hits    (res_hits),
    .res_part    (res_part),
    .res_nomatch (res_nomatch),
    .res_one_hit (res_one_hit),
    .res_one_idx (res_one_idx)
);

// File: tb/partsel_tcam_test.sv
// Self-checking bench for partsel_tcam with a behavioural cycle model.
module partsel_tcam_test;

    localparam int KEY_W  = 8;
    localparam int NENT   = 16;
    localparam int NPART  = 4;
    localparam int IDX_W  = 4;
    localparam int PART_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_target = 1'b0;
    logic [IDX_W-1:0]  wr_addr = '0;
    logic [KEY_W-1:0]  wr_value = '0;
    logic [KEY_W-1:0]  wr_care = '0;
    logic [PART_W-1:0] wr_part = '0;
    logic              srch_valid = 1'b0;
    logic [KEY_W-1:0]  srch_key = '0;
    logic              res_valid;
    logic [NENT-1:0]   res_hits;
    logic [PART_W-1:0] res_part;
    logic              res_nomatch;
    logic              res_one_hit;
    logic [IDX_W-1:0]  res_one_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    partsel_tcam #(.KEY_W(KEY_W), .NUM_ENT(NENT), .NUM_PART(NPART)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
        .wr_addr(wr_addr), .wr_value(wr_value), .wr_care(wr_care),
        .wr_part(wr_part), .srch_valid(srch_valid), .srch_key(srch_key),
        .res_valid(res_valid), .res_hits(res_hits), .res_part(res_part),
        .res_nomatch(res_nomatch), .res_one_hit(res_one_hit),
        .res_one_idx(res_one_idx)
    );

    // Behavioural model state
    logic [KEY_W-1:0] m_val [NENT];
    logic [KEY_W-1:0] m_care[NENT];
    int               m_part[NENT];
    bit               m_ev  [NENT];
    logic [KEY_W-1:0] c_val [NPART];
    logic [KEY_W-1:0] c_care[NPART];
    bit               c_v   [NPART];
    logic             e_valid, e_nomatch, e_onehit;
    logic [NENT-1:0]  e_hits;
    int               e_part, e_oneidx;

    // Model update at each active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) m_ev[i] = 1'b0;
            for (int p = 0; p < NPART; p++) c_v[p] = 1'b0;
            e_valid = 0; e_nomatch = 0; e_onehit = 0;
            e_hits = '0; e_part = 0; e_oneidx = 0;
        end else begin
            e_valid = srch_valid;
            if (srch_valid) begin
                int sel;
                sel = -1;
                for (int p = 0; p < NPART; p++)
                    if (sel < 0 && c_v[p] && (((srch_key ^ c_val[p]) & c_care[p]) == 0)) sel = p;
                e_nomatch = (sel < 0);
                e_part    = (sel < 0) ? 0 : sel;
                e_hits    = '0;
                for (int i = 0; i < NENT; i++)
                    if (m_ev[i] && m_part[i] == sel && (((srch_key ^ m_val[i]) & m_care[i]) == 0))
                        e_hits[i] = 1'b1;
                e_onehit = (sel == NPART - 1) && (e_hits != 0);
                e_oneidx = 0;
                if (e_onehit)
                    for (int i = NENT - 1; i >= 0; i--) if (e_hits[i]) e_oneidx = i;
            end
            if (wr_en && !wr_target) begin
                m_val[wr_addr] = wr_value; m_care[wr_addr] = wr_care;
                m_part[wr_addr] = int'(wr_part); m_ev[wr_addr] = 1'b1;
            end
            if (wr_en && wr_target) begin
                c_val[wr_addr[PART_W-1:0]] = wr_value;
                c_care[wr_addr[PART_W-1:0]] = wr_care;
                c_v[wr_addr[PART_W-1:0]] = 1'b1;
            end
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_eq("R5 res_valid", 32'(res_valid), 32'(e_valid));
            check_eq("R1/R4 res_hits", 32'(res_hits), 32'(e_hits));
            check_eq("R2 res_part", 32'(res_part), 32'(e_part));
            check_eq("R3 res_nomatch", 32'(res_nomatch), 32'(e_nomatch));
            check_eq("R8 res_one_hit", 32'(res_one_hit), 32'(e_onehit));
            check_eq("R8 res_one_idx", 32'(res_one_idx), 32'(e_oneidx));
        end
    end

    function automatic void tern(input string s, output logic [7:0] v, output logic [7:0] c);
        for (int i = 0; i < 8; i++) begin
            v[7-i] = (s[i] == "1");
            c[7-i] = (s[i] != "x");
        end
    endfunction

    task automatic put_entry(input int idx, input string s, input int part);
        logic [7:0] v, c;
        tern(s, v, c);
        wr_en = 1; wr_target = 0; wr_addr = IDX_W'(idx);
        wr_value = v; wr_care = c; wr_part = PART_W'(part);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic put_code(input int part, input string s);
        logic [7:0] v, c;
        tern(s, v, c);
        wr_en = 1; wr_target = 1; wr_addr = IDX_W'(part);
        wr_value = v; wr_care = c;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic search(input logic [7:0] k);
        srch_valid = 1; srch_key = k;
        @(negedge clk);
        srch_valid = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7: reset state
        check_eq("R7 reset valid", 32'(res_valid), 0);
        check_eq("R7 reset hits", 32'(res_hits), 0);
        search(8'hD2);
        check_eq("R7 empty search nomatch", 32'(res_nomatch), 1);

        put_code(0, "0xx0xxxx");
        put_code(1, "1x01xxxx");
        put_code(2, "1010xxxx");
        put_code(3, "xxxxxxxx");
        put_entry(0, "0xx01110", 0);
        put_entry(1, "00101xx0", 0);
        put_entry(2, "0110x1x0", 0);
        put_entry(4, "1101xx10", 1);
        put_entry(5, "11x1xxxx", 1);
        put_entry(6, "100x1xx0", 1);
        put_entry(7, "1001x110", 1);
        put_entry(8, "1x01xx10", 1);
        put_entry(9, "1010xxxx", 2);
        put_entry(10, "xxxxxxxx", 2);
        put_entry(12, "1011001x", 3);
        put_entry(13, "0111x010", 3);

        // R9 example key
        search(8'b11010010);
        check_eq("R9 part", 32'(res_part), 1);
        check_eq("R9 hits", 32'(res_hits), 32'h0130);
        // R4: all-don't-care entry 10 in group 2 stays zero
        check_eq("R4 gated entry", 32'(res_hits[10]), 0);

        // R8: catch-all group single hits
        search(8'b10110010);
        check_eq("R8 one_hit", 32'(res_one_hit), 1);
        check_eq("R8 one_idx", 32'(res_one_idx), 12);
        search(8'b01110010);
        check_eq("R8 one_idx b", 32'(res_one_idx), 13);

        // R5: outputs hold with no search
        @(negedge clk);
        check_eq("R5 hold idx", 32'(res_one_idx), 13);

        // R2: overlapping codes, lowest wins
        put_code(2, "1xxxxxxx");
        search(8'b11010010);
        check_eq("R2 lowest wins", 32'(res_part), 1);
        search(8'b10100000);
        check_eq("R2 group 2", 32'(res_part), 2);

        // R6: write then search in the next cycle
        put_entry(15, "11110000", 2);
        search(8'hF0);
        check_eq("R6 new entry hit", 32'(res_hits), 32'h8400);

        // R3: no code matches
        put_code(3, "1111xxxx");
        search(8'b01110010);
        check_eq("R3 nomatch", 32'(res_nomatch), 1);
        check_eq("R3 hits zero", 32'(res_hits), 0);

        // R1: random keys against the model
        put_code(3, "xxxxxxxx");
        for (int n = 0; n < 300; n++) begin
            search(8'($urandom));
            if (n % 3 == 0) @(negedge clk);
        end
        repeat (2) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule